// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block steps a small 16-bit RISC core through exception entry and exit. Requests come in on separate lines for three interrupt classes (non-maskable, emulator and maskable) and six trap classes. When the core is idle the sequencer picks one request, saves the interrupted program counter and status word on a downward-growing interrupt stack, fetches the handler address from a dispatch table, and loads the new PC and a status word with interrupts masked back into the datapath. A return request reverses this by popping the saved frame.

Program counter, stack pointer and table base are 21-bit word addresses, and memory words are 16 bits wide. The saved PC therefore takes two stack words. A `hold` output stalls fetch and decode while a sequence runs. It stays high for a fixed number of drain cycles afterwards, and that same drain can be started alone for control instructions that need the pipeline serialized. The stack pointer and table base are loaded through a shared write port.

Top module: `exc_ctrl`

## Requirements
- R1: Requests are ranked non-maskable (vector 1) above emulator (vector 2) above traps above maskable (vector 9). Trap lines are `trap_req[0]`..`[5]`: supervisor call, divide by zero, flag, breakpoint, trace and undefined. A lower index wins, and trap k takes vector 3+k. `exc_taken` and `exc_vector` report the choice combinationally in the idle cycle of acceptance.
- R2: A maskable request is accepted only while bit 9 of `cur_psr` is 1. Otherwise it is ignored, and `hold` and `isp_value` stay unchanged.
- R3: Entry writes three words. Let S be the stack pointer at acceptance. The status word goes to S-1, the PC bits 20:16 (zero-extended) go to S-2, and the PC bits 15:0 go to S-3, in that order on consecutive cycles. The stack pointer ends at S-3.
- R4: After the pushes, the word at table base + 2 x vector is read and loaded into the PC, zero-extended, with `pc_load` high for one cycle.
- R5: The status word loaded on entry equals the saved one with bit 9 cleared.
- R6: A return reads S, S+1 and S+2 as PC low, PC high and status word. It then loads the PC {high[4:0], low} and the status word together, and the stack pointer ends at S+3.
- R7: `hold` is high from the cycle after acceptance until the sequence ends, then for DRAIN_CYC (default 2) more cycles. An entry therefore holds 4+DRAIN_CYC cycles and a return 3+DRAIN_CYC. A serialize request alone holds DRAIN_CYC cycles. Memory is accessed only while `hold` is high.
- R8: No request is accepted while `hold` is high, so exactly one exception is served per entry.
- R9: Writes to the stack pointer or table base take effect on the next edge when idle. They are ignored while `hold` is high.
- R10: During reset `hold`, `mem_req` and `isp_value` are 0.
- R11: Exception requests take precedence over a return request, and a return takes precedence over a serialize request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_req | input | 1 | Non-maskable interrupt request |
| emu_req | input | 1 | Emulator interrupt request |
| trap_req | input | 6 | Trap requests, one bit per trap class |
| irq_req | input | 1 | Maskable interrupt request |
| retx_req | input | 1 | Return-from-exception request |
| serial_req | input | 1 | Serialize request (drain only) |
| cur_pc | input | 21 | PC of the interrupted instruction |
| cur_psr | input | 16 | Current status word |
| isp_wr | input | 1 | Load stack pointer from areg_wdata |
| intbase_wr | input | 1 | Load table base from areg_wdata |
| areg_wdata | input | 21 | Address register write data |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 21 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the same cycle |
| pc_load | output | 1 | Load PC from pc_value |
| pc_value | output | 21 | New PC |
| psr_load | output | 1 | Load status word from psr_value |
| psr_value | output | 16 | New status word |
| hold | output | 1 | Stall fetch and decode |
| exc_taken | output | 1 | An exception is accepted this cycle |
| exc_vector | output | 4 | Vector of the accepted exception |
| isp_value | output | 21 | Current stack pointer |

## Verification
The bench drives the arbiter with single requests, with every line raised at once, and with pairs of traps and trap-plus-interrupt mixes. Each pattern separates one link in the priority chain, and a wrong rank shows up as a wrong vector and a wrong handler address. Every entry is followed by a return from the same stack position, so the frame layout and PC high/low split are checked in both directions. The bench also runs a masked maskable request, competing return and serialize requests whose hold lengths differ, and writes to the address registers made during a sequence and made while idle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PUSH_PSR, ST_PUSH_PCH, ST_PUSH_PCL, ST_VEC,
    ST_POP_PCL, ST_POP_PCH, ST_POP_PSR, ST_DRAIN
  } seq_t;

  localparam int VEC_NMI       = 1;
  localparam int VEC_EMU       = 2;
  localparam int VEC_TRAP_BASE = 3;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter import exc_pkg::*; #(
  parameter int NTRAP = 6,
  parameter int VW    = 4
) (
  input  logic             nmi,
  input  logic             emu,
  input  logic [NTRAP-1:0] trap,
  input  logic             irq,
  input  logic             irq_en,
  output logic [VW-1:0]    vec,
  output logic             any
);
  localparam logic [VW-1:0] V_IRQ = VW'(VEC_TRAP_BASE + NTRAP);

  logic [VW-1:0] trap_vec;

  // lowest index wins: scan downward so the last hit is the smallest index
  always_comb begin
    trap_vec = '0;
    for (int i = NTRAP - 1; i >= 0; i--) begin
      if (trap[i]) trap_vec = VW'(VEC_TRAP_BASE + i);
    end
  end

  always_comb begin
    if (nmi)                vec = VW'(VEC_NMI);
    else if (emu)           vec = VW'(VEC_EMU);
    else if (|trap)         vec = trap_vec;
    else if (irq && irq_en) vec = V_IRQ;
    else                    vec = '0;
  end

  assign any = (vec != '0);
endmodule

// File: rtl/exc_stack_ptr.sv
module exc_stack_ptr #(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec,
  input  logic          inc,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (dec)  ptr <= ptr - ONE;
    else if (inc)  ptr <= ptr + ONE;
    else if (load) ptr <= load_val;
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl import exc_pkg::*; #(
  parameter int AW        = 21,
  parameter int DW        = 16,
  parameter int NTRAP     = 6,
  parameter int VW        = 4,
  parameter int IEN_BIT   = 9,
  parameter int DRAIN_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_req,
  input  logic             emu_req,
  input  logic [NTRAP-1:0] trap_req,
  input  logic             irq_req,
  input  logic             retx_req,
  input  logic             serial_req,
  input  logic [AW-1:0]    cur_pc,
  input  logic [DW-1:0]    cur_psr,
  input  logic             isp_wr,
  input  logic             intbase_wr,
  input  logic [AW-1:0]    areg_wdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             pc_load,
  output logic [AW-1:0]    pc_value,
  output logic             psr_load,
  output logic [DW-1:0]    psr_value,
  output logic             hold,
  output logic             exc_taken,
  output logic [VW-1:0]    exc_vector,
  output logic [AW-1:0]    isp_value
);
  localparam int HIW = AW - DW;
  localparam int CW  = $clog2(DRAIN_CYC + 1);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [CW-1:0] DRAIN_LAST = CW'(DRAIN_CYC - 1);

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base,
                                               input logic [VW-1:0] v);
    return base + (AW'(v) << 1);
  endfunction

  function automatic logic [DW-1:0] mask_ien(input logic [DW-1:0] p);
    logic [DW-1:0] r;
    r = p;
    r[IEN_BIT] = 1'b0;
    return r;
  endfunction

  seq_t            state;
  logic [CW-1:0]   drain_cnt;
  logic [AW-1:0]   sv_pc;
  logic [DW-1:0]   sv_psr;
  logic [VW-1:0]   sv_vec;
  logic [DW-1:0]   pop_lo;
  logic [HIW-1:0]  pop_hi;
  logic [AW-1:0]   intbase_q;

  logic [VW-1:0]   arb_vec;
  logic            arb_any;
  logic            idle;
  logic            accept_exc, accept_ret, accept_ser;
  logic            push_cyc, pop_cyc, vec_fetch;

  exc_arbiter #(.NTRAP(NTRAP), .VW(VW)) u_arb (
    .nmi(nmi_req), .emu(emu_req), .trap(trap_req), .irq(irq_req),
    .irq_en(cur_psr[IEN_BIT]), .vec(arb_vec), .any(arb_any)
  );

  assign idle       = (state == ST_IDLE);
  assign accept_exc = idle && arb_any;
  assign accept_ret = idle && !arb_any && retx_req;
  assign accept_ser = idle && !arb_any && !retx_req && serial_req;
  assign push_cyc   = (state == ST_PUSH_PSR) || (state == ST_PUSH_PCH) ||
                      (state == ST_PUSH_PCL);
  assign pop_cyc    = (state == ST_POP_PCL) || (state == ST_POP_PCH) ||
                      (state == ST_POP_PSR);
  assign vec_fetch  = (state == ST_VEC);

  exc_stack_ptr #(.AW(AW)) u_isp (
    .clk(clk), .rst_n(rst_n), .dec(push_cyc), .inc(pop_cyc),
    .load(isp_wr && idle), .load_val(areg_wdata), .ptr(isp_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   intbase_q <= '0;
    else if (intbase_wr && idle)  intbase_q <= areg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      drain_cnt <= '0;
      sv_pc     <= '0;
      sv_psr    <= '0;
      sv_vec    <= '0;
      pop_lo    <= '0;
      pop_hi    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          drain_cnt <= '0;
          if (accept_exc) begin
            sv_pc  <= cur_pc;
            sv_psr <= cur_psr;
            sv_vec <= arb_vec;
            state  <= ST_PUSH_PSR;
          end else if (accept_ret) begin
            state <= ST_POP_PCL;
          end else if (accept_ser) begin
            state <= ST_DRAIN;
          end
        end
        ST_PUSH_PSR: state <= ST_PUSH_PCH;
        ST_PUSH_PCH: state <= ST_PUSH_PCL;
        ST_PUSH_PCL: state <= ST_VEC;
        ST_VEC:      state <= ST_DRAIN;
        ST_POP_PCL: begin
          pop_lo <= mem_rdata;
          state  <= ST_POP_PCH;
        end
        ST_POP_PCH: begin
          pop_hi <= mem_rdata[HIW-1:0];
          state  <= ST_POP_PSR;
        end
        ST_POP_PSR:  state <= ST_DRAIN;
        ST_DRAIN: begin
          if (drain_cnt == DRAIN_LAST) begin
            drain_cnt <= '0;
            state     <= ST_IDLE;
          end else begin
            drain_cnt <= drain_cnt + CW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = isp_value;
    mem_wdata = '0;
    pc_load   = 1'b0;
    pc_value  = '0;
    psr_load  = 1'b0;
    psr_value = '0;
    case (state)
      ST_PUSH_PSR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = isp_value - ONE; mem_wdata = sv_psr;
      end
      ST_PUSH_PCH: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = isp_value - ONE; mem_wdata = DW'(sv_pc[AW-1:DW]);
      end
      ST_PUSH_PCL: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = isp_value - ONE; mem_wdata = sv_pc[DW-1:0];
      end
      ST_VEC: begin
        mem_req   = 1'b1;
        mem_addr  = slot_addr(intbase_q, sv_vec);
        pc_load   = 1'b1;
        pc_value  = AW'(mem_rdata);
        psr_load  = 1'b1;
        psr_value = mask_ien(sv_psr);
      end
      ST_POP_PCL, ST_POP_PCH: mem_req = 1'b1;
      ST_POP_PSR: begin
        mem_req   = 1'b1;
        pc_load   = 1'b1;
        pc_value  = {pop_hi, pop_lo};
        psr_load  = 1'b1;
        psr_value = mem_rdata;
      end
      default: ;
    endcase
  end

  assign hold       = !idle;
  assign exc_taken  = accept_exc;
  assign exc_vector = accept_exc ? arb_vec : '0;
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int AW      = 21,
  parameter int DW      = 16,
  parameter int NTRAP   = 6,
  parameter int VW      = 4,
  parameter int IEN_BIT = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exc_taken,
  input logic [VW-1:0] exc_vector,
  input logic [DW-1:0] cur_psr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic          hold,
  input logic [AW-1:0] isp_value,
  input logic          pc_load,
  input logic          psr_load,
  input logic [DW-1:0] psr_value,
  input logic          push_cyc,
  input logic          pop_cyc,
  input logic          vec_fetch
);
  localparam logic [VW-1:0] V_IRQ = VW'(3 + NTRAP);
  localparam logic [AW-1:0] ONE   = AW'(1);

  logic edge_seen;
  always_ff @(posedge clk) edge_seen <= 1'b1;

  always @(negedge clk) begin
    if (edge_seen === 1'b1 && !rst_n) begin
      assert_reset_quiet_R10: assert (!hold && !mem_req && isp_value == '0);
    end
  end

  assert_irq_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_taken && exc_vector == V_IRQ) |-> cur_psr[IEN_BIT]);

  assert_first_push_psr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |=> (mem_req && mem_we && mem_wdata == $past(cur_psr)));

  assert_push_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_cyc |=> (isp_value == $past(isp_value) - ONE));

  assert_ien_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |-> (psr_load && !psr_value[IEN_BIT]));

  assert_pop_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_cyc |=> (isp_value == $past(isp_value) + ONE));

  assert_mem_under_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> hold);

  assert_drain_after_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> hold);

  assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> !hold);

  assert_isp_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !push_cyc && !pop_cyc) |=> $stable(isp_value));
endmodule

bind exc_ctrl exc_ctrl_chk #(
  .AW(AW), .DW(DW), .NTRAP(NTRAP), .VW(VW), .IEN_BIT(IEN_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_taken(exc_taken), .exc_vector(exc_vector),
  .cur_psr(cur_psr), .mem_req(mem_req), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .hold(hold), .isp_value(isp_value),
  .pc_load(pc_load), .psr_load(psr_load), .psr_value(psr_value),
  .push_cyc(push_cyc), .pop_cyc(pop_cyc), .vec_fetch(vec_fetch)
);

// File: tb/exc_ctrl_test.sv
`timescale 1ns/1ps
module exc_ctrl_test;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam logic [AW-1:0] STK  = 21'h0000F0;
  localparam logic [AW-1:0] BASE = 21'h000040;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, nmi_req, emu_req, irq_req, retx_req, serial_req;
  logic [5:0] trap_req;
  logic [AW-1:0] cur_pc, areg_wdata, mem_addr, pc_value, isp_value;
  logic [DW-1:0] cur_psr, mem_wdata, mem_rdata, psr_value;
  logic isp_wr, intbase_wr, mem_req, mem_we, pc_load, psr_load, hold, exc_taken;
  logic [3:0] exc_vector;

  exc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .emu_req(emu_req),
    .trap_req(trap_req), .irq_req(irq_req), .retx_req(retx_req),
    .serial_req(serial_req), .cur_pc(cur_pc), .cur_psr(cur_psr),
    .isp_wr(isp_wr), .intbase_wr(intbase_wr), .areg_wdata(areg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_load(pc_load),
    .pc_value(pc_value), .psr_load(psr_load), .psr_value(psr_value),
    .hold(hold), .exc_taken(exc_taken), .exc_vector(exc_vector),
    .isp_value(isp_value)
  );

  logic [15:0] mem [0:255];
  always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  assign mem_rdata = mem[mem_addr[7:0]];

  logic [AW-1:0] got_pc;
  logic [DW-1:0] got_psr;
  int loads;
  always @(negedge clk) if (pc_load) begin
    got_pc = pc_value; got_psr = psr_value; loads++;
  end

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (hold && n < 50) begin @(negedge clk); n++; end
  endtask

  task automatic clear_reqs();
    nmi_req = 0; emu_req = 0; trap_req = '0; irq_req = 0; retx_req = 0; serial_req = 0;
  endtask

  // {nmi, emu, trap[5:0], irq, psr_ien, expected vector, pad}
  localparam logic [15:0] TAB [10] = '{
    {1'b1, 1'b0, 6'b000000, 1'b0, 1'b0, 4'd1, 2'b0},
    {1'b1, 1'b1, 6'b111111, 1'b1, 1'b1, 4'd1, 2'b0},
    {1'b0, 1'b1, 6'b000001, 1'b1, 1'b1, 4'd2, 2'b0},
    {1'b0, 1'b0, 6'b100100, 1'b0, 1'b0, 4'd5, 2'b0},
    {1'b0, 1'b0, 6'b100000, 1'b0, 1'b1, 4'd8, 2'b0},
    {1'b0, 1'b0, 6'b001000, 1'b1, 1'b1, 4'd6, 2'b0},
    {1'b0, 1'b0, 6'b000000, 1'b1, 1'b1, 4'd9, 2'b0},
    {1'b0, 1'b0, 6'b010000, 1'b1, 1'b0, 4'd7, 2'b0},
    {1'b0, 1'b0, 6'b000010, 1'b0, 1'b0, 4'd4, 2'b0},
    {1'b0, 1'b0, 6'b000001, 1'b1, 1'b1, 4'd3, 2'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    logic [AW-1:0] pc;
    logic [DW-1:0] psr;
    logic [3:0] ev;
    rst_n = 0; clear_reqs(); cur_pc = '0; cur_psr = '0;
    isp_wr = 0; intbase_wr = 0; areg_wdata = '0; loads = 0;
    for (int a = 0; a < 256; a++) mem[a] = 16'h0000;
    for (int v = 1; v < 10; v++) mem[BASE[7:0] + 2*v] = 16'hA000 + 16'(v);
    repeat (3) @(negedge clk);
    chk(!hold && !mem_req && isp_value == '0, "R10 reset state", {hold, mem_req, isp_value}, 0);
    rst_n = 1;
    @(negedge clk);
    isp_wr = 1; intbase_wr = 0; areg_wdata = STK;
    @(negedge clk);
    isp_wr = 0; intbase_wr = 1; areg_wdata = BASE;
    @(negedge clk);
    intbase_wr = 0;
    chk(isp_value == STK, "R9 idle isp write", isp_value, STK);

    // table walk: entry then return for each pattern
    for (int i = 0; i < 10; i++) begin
      pc  = {5'(i + 1), 16'h1230 + 16'(i)};
      psr = 16'h00A0 | (16'(TAB[i][6]) << 9) | 16'(i);
      ev  = TAB[i][5:2];
      nmi_req = TAB[i][15]; emu_req = TAB[i][14]; trap_req = TAB[i][13:8];
      irq_req = TAB[i][7]; cur_pc = pc; cur_psr = psr;
      #1;
      chk(exc_taken && exc_vector == ev, "R1 priority vector", {exc_taken, exc_vector}, {1'b1, ev});
      @(negedge clk);
      clear_reqs();
      wait_idle(n);
      chk(n == 6, "R7 entry hold length", n, 6);
      chk(mem[STK[7:0] - 1] == psr, "R3 saved status at S-1", mem[STK[7:0] - 1], psr);
      chk(mem[STK[7:0] - 2] == 16'(i + 1), "R3 saved PC high at S-2", mem[STK[7:0] - 2], i + 1);
      chk(mem[STK[7:0] - 3] == pc[15:0], "R3 saved PC low at S-3", mem[STK[7:0] - 3], pc[15:0]);
      chk(isp_value == STK - 3, "R3 stack pointer after entry", isp_value, STK - 3);
      chk(got_pc == {5'b0, 16'hA000 + 16'(ev)}, "R4 dispatch PC", got_pc, {5'b0, 16'hA000 + 16'(ev)});
      chk(got_psr == (psr & 16'hFDFF), "R5 entry status masked", got_psr, psr & 16'hFDFF);
      cur_psr = 16'hFFFF;
      retx_req = 1;
      @(negedge clk);
      retx_req = 0;
      wait_idle(n);
      chk(n == 5, "R7 return hold length", n, 5);
      chk(got_pc == pc, "R6 restored PC", got_pc, pc);
      chk(got_psr == psr, "R6 restored status", got_psr, psr);
      chk(isp_value == STK, "R6 stack pointer after return", isp_value, STK);
    end

    // masked maskable interrupt
    irq_req = 1; cur_psr = 16'h0000;
    #1;
    chk(!exc_taken, "R2 masked irq not taken", exc_taken, 0);
    n = loads;
    repeat (4) begin
      @(negedge clk);
      chk(!hold && isp_value == STK, "R2 masked irq no effect", {hold, isp_value}, STK);
    end
    chk(loads == n, "R2 masked irq no PC load", loads, n);
    irq_req = 0;

    // serialize alone
    serial_req = 1;
    @(negedge clk);
    serial_req = 0;
    wait_idle(n);
    chk(n == 2, "R7 serialize hold length", n, 2);

    // exception beats return; request held through sequence; register writes ignored while busy
    nmi_req = 1; retx_req = 1; cur_pc = 21'h1F_0042; cur_psr = 16'h0200;
    #1;
    chk(exc_taken && exc_vector == 4'd1, "R11 exception over return", {exc_taken, exc_vector}, 5'h11);
    @(negedge clk);
    retx_req = 0; isp_wr = 1; intbase_wr = 1; areg_wdata = 21'h000008;
    n = 0;
    for (int k = 0; k < 6; k++) begin
      if (exc_taken) n++;
      @(negedge clk);
      isp_wr = 0; intbase_wr = 0;
    end
    chk(n == 0, "R8 no acceptance while busy", n, 0);
    nmi_req = 0;
    #1;
    chk(isp_value == STK - 3, "R9 busy isp write ignored", isp_value, STK - 3);
    chk(got_pc == {5'b0, 16'hA001}, "R9 busy base write ignored", got_pc, {5'b0, 16'hA001});

    // return beats serialize
    retx_req = 1; serial_req = 1;
    @(negedge clk);
    retx_req = 0; serial_req = 0;
    wait_idle(n);
    chk(n == 5 && isp_value == STK, "R11 return over serialize", {n[7:0], isp_value}, {8'd5, STK});
    chk(got_pc == 21'h1F_0042, "R6 restored PC high bits", got_pc, 21'h1F_0042);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule